// File: doc/BRIEF.md
# Diagnosis Result Arbitrator

This block turns one round of classifier output into one settled fault diagnosis. Each round it receives nine signed scores, one per fault class. A class is a fault model (transient, intermittent or permanent) paired with a structure (instruction decoder, address generation, or integer/floating-point execution). A negative score marks a class as hit. If exactly one class is hit, that class is the diagnosis. If no class is hit, or several are, the classifier's answer is not trusted. The block then takes the structure from the dedicated-trap indication, which the symptom collector reports alongside the scores. It keeps a fault model only if the hit pattern still names one model within that structure. If the pattern is rejected and no usable trap indication is present, the block reports an undiagnosed result and asks for another round.

After an answer that came straight from the classifier, the block keeps watching the symptom stream. A run of further symptoms means the unique answer was probably wrong. When that run reaches a parameterised length, the block asks for the classifier weights to be adjusted, which also starts a new diagnosis round. Answers obtained through the trap fallback are not watched in this way. Every decision is registered: its outputs appear one clock after the scores are strobed and stay in place until the next decision.

Top module: `diag_arbiter`

## Requirements
- R1: While reset is asserted, and at its release, the model and structure codes read 3 (unknown), and diag_valid, fallback_used, retrain_req and again_req are all low.
- R2: Class k = model*3 + structure occupies score_bus[k*SCORE_W +: SCORE_W] as a two's-complement value. A strictly negative value is a hit. Zero and positive values are misses.
- R3: When exactly one class is hit, the cycle after score_valid shows diag_valid high, the model and structure codes of that class, and fallback_used and again_req low. The trap inputs have no effect in this case. Model codes: 0 transient, 1 intermittent, 2 permanent. Structure codes: 0 decoder, 1 address generation, 2 execution.
- R4: When no class is hit and a usable trap indication is present (trap_hit high and trap_struct below 3), the decision shows structure = trap_struct, model = 3 and fallback_used high.
- R5: When two or more classes are hit and a usable trap indication is present, the decision shows structure = trap_struct and fallback_used high. The model is the model of the single hit inside that structure's column if there is exactly one such hit, and 3 otherwise.
- R6: When zero or several classes are hit and no usable trap indication is present (trap_hit low, or trap_struct = 3), the decision shows model 3, structure 3, fallback_used low, and again_req high for that one cycle.
- R7: After a unique decision, the PERSIST_LIMIT-th symptom_pulse (counted over cycles without score_valid) raises retrain_req for exactly one cycle, in the cycle after that pulse. Watching then stops, so further symptoms raise nothing.
- R8: Symptoms that arrive before any decision, or after a fallback or undiagnosed decision, never raise retrain_req.
- R9: A new score_valid clears the symptom count. A symptom in the same cycle as score_valid is not counted.
- R10: In cycles without score_valid, diag_valid and again_req stay low, and the model, structure and fallback outputs keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| score_valid | input | 1 | Strobe: score_bus and trap inputs hold a round |
| score_bus | input | 9*SCORE_W | Nine signed class scores, model-major |
| trap_hit | input | 1 | A dedicated trap has been seen this round |
| trap_struct | input | 2 | Structure named by the dedicated trap |
| symptom_pulse | input | 1 | One further symptom observed |
| diag_valid | output | 1 | One-cycle decision strobe |
| diag_model | output | 2 | Fault model code, 3 = unknown |
| diag_struct | output | 2 | Structure code, 3 = unknown |
| fallback_used | output | 1 | Decision came from the trap fallback |
| retrain_req | output | 1 | Pulse: adjust weights, new round |
| again_req | output | 1 | Pulse: undiagnosed, run another round |

## Verification
The bench builds the block with SCORE_W = 12 and PERSIST_LIMIT = 2. The 12-bit width lets the score table include the most negative value and exact zeros, so the sign boundary is exercised at both ends. A limit of two separates the first symptom after a unique answer, which must stay silent, from the second, which must request retraining. It also lets a fresh score strobe land between the two, showing that the count is cleared. Column-level fallback cases cover one hit, several hits and no hit inside the trap's structure.

// File: rtl/diag_arb_pkg.sv
package diag_arb_pkg;
  localparam int N_MODELS  = 3;
  localparam int N_STRUCTS = 3;
  localparam int N_CLASSES = N_MODELS * N_STRUCTS;
  localparam logic [1:0] CODE_UNKNOWN = 2'd3;

  typedef enum logic [1:0] {
    DEC_NONE     = 2'd0,
    DEC_UNIQUE   = 2'd1,
    DEC_FALLBACK = 2'd2
  } dec_kind_t;
endpackage

// File: rtl/diag_hit_decode.sv
module diag_hit_decode #(
  parameter int SCORE_W = 12,
  parameter int N_CLS   = 9
) (
  input  logic [N_CLS*SCORE_W-1:0] score_bus,
  output logic [N_CLS-1:0]         hits
);
  for (genvar k = 0; k < N_CLS; k++) begin : g_cls
    assign hits[k] = ($signed(score_bus[k*SCORE_W +: SCORE_W]) < 0);
  end
endmodule

// File: rtl/diag_select.sv
module diag_select
  import diag_arb_pkg::*;
(
  input  logic [N_CLASSES-1:0] hits,
  input  logic                 trap_hit,
  input  logic [1:0]           trap_struct,
  output dec_kind_t            kind,
  output logic [1:0]           sel_model,
  output logic [1:0]           sel_struct
);
  localparam int CNT_W = $clog2(N_CLASSES + 1);

  logic [CNT_W-1:0] total_hits;
  logic [CNT_W-1:0] col_hits;
  logic [1:0]       uniq_model;
  logic [1:0]       uniq_struct;
  logic [1:0]       col_model;
  logic             trap_ok;

  assign trap_ok = trap_hit && (trap_struct < 2'(N_STRUCTS));

  always_comb begin
    total_hits  = '0;
    col_hits    = '0;
    uniq_model  = CODE_UNKNOWN;
    uniq_struct = CODE_UNKNOWN;
    col_model   = CODE_UNKNOWN;
    for (int m = 0; m < N_MODELS; m++) begin
      for (int s = 0; s < N_STRUCTS; s++) begin
        if (hits[m*N_STRUCTS + s]) begin
          total_hits  = total_hits + CNT_W'(1);
          uniq_model  = 2'(m);
          uniq_struct = 2'(s);
          if (2'(s) == trap_struct) begin
            col_hits  = col_hits + CNT_W'(1);
            col_model = 2'(m);
          end
        end
      end
    end
  end

  always_comb begin
    if (total_hits == CNT_W'(1)) begin
      kind       = DEC_UNIQUE;
      sel_model  = uniq_model;
      sel_struct = uniq_struct;
    end else if (trap_ok) begin
      kind       = DEC_FALLBACK;
      sel_struct = trap_struct;
      sel_model  = (total_hits > CNT_W'(1) && col_hits == CNT_W'(1)) ? col_model : CODE_UNKNOWN;
    end else begin
      kind       = DEC_NONE;
      sel_model  = CODE_UNKNOWN;
      sel_struct = CODE_UNKNOWN;
    end
  end
endmodule

// File: rtl/diag_persist.sv
module diag_persist #(
  parameter int PERSIST_LIMIT = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic score_valid,
  input  logic unique_dec,
  input  logic symptom_pulse,
  output logic retrain_req
);
  localparam int CNT_W = (PERSIST_LIMIT < 2) ? 1 : $clog2(PERSIST_LIMIT);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERSIST_LIMIT - 1);

  logic             locked_q, locked_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             retrain_q, retrain_d;

  always_comb begin
    locked_d  = locked_q;
    cnt_d     = cnt_q;
    retrain_d = 1'b0;
    if (score_valid) begin
      locked_d = unique_dec;
      cnt_d    = '0;
    end else if (locked_q && symptom_pulse) begin
      if (cnt_q == LAST) begin
        retrain_d = 1'b1;
        locked_d  = 1'b0;
        cnt_d     = '0;
      end else begin
        cnt_d = cnt_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked_q  <= 1'b0;
      cnt_q     <= '0;
      retrain_q <= 1'b0;
    end else begin
      locked_q  <= locked_d;
      cnt_q     <= cnt_d;
      retrain_q <= retrain_d;
    end
  end

  assign retrain_req = retrain_q;
endmodule

// File: rtl/diag_arbiter.sv
module diag_arbiter
  import diag_arb_pkg::*;
#(
  parameter int SCORE_W       = 12,
  parameter int PERSIST_LIMIT = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         score_valid,
  input  logic [N_CLASSES*SCORE_W-1:0] score_bus,
  input  logic                         trap_hit,
  input  logic [1:0]                   trap_struct,
  input  logic                         symptom_pulse,
  output logic                         diag_valid,
  output logic [1:0]                   diag_model,
  output logic [1:0]                   diag_struct,
  output logic                         fallback_used,
  output logic                         retrain_req,
  output logic                         again_req
);
  logic [N_CLASSES-1:0] hits;
  dec_kind_t            kind;
  logic [1:0]           sel_model, sel_struct;

  logic       valid_q, valid_d;
  logic [1:0] model_q, model_d;
  logic [1:0] struct_q, struct_d;
  logic       fb_q, fb_d;
  logic       again_q, again_d;

  diag_hit_decode #(.SCORE_W(SCORE_W), .N_CLS(N_CLASSES)) u_decode (
    .score_bus (score_bus),
    .hits      (hits)
  );

  diag_select u_select (
    .hits        (hits),
    .trap_hit    (trap_hit),
    .trap_struct (trap_struct),
    .kind        (kind),
    .sel_model   (sel_model),
    .sel_struct  (sel_struct)
  );

  diag_persist #(.PERSIST_LIMIT(PERSIST_LIMIT)) u_persist (
    .clk           (clk),
    .rst_n         (rst_n),
    .score_valid   (score_valid),
    .unique_dec    (kind == DEC_UNIQUE),
    .symptom_pulse (symptom_pulse),
    .retrain_req   (retrain_req)
  );

  always_comb begin
    valid_d  = 1'b0;
    again_d  = 1'b0;
    model_d  = model_q;
    struct_d = struct_q;
    fb_d     = fb_q;
    if (score_valid) begin
      valid_d  = 1'b1;
      model_d  = sel_model;
      struct_d = sel_struct;
      fb_d     = (kind == DEC_FALLBACK);
      again_d  = (kind == DEC_NONE);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q  <= 1'b0;
      model_q  <= CODE_UNKNOWN;
      struct_q <= CODE_UNKNOWN;
      fb_q     <= 1'b0;
      again_q  <= 1'b0;
    end else begin
      valid_q  <= valid_d;
      model_q  <= model_d;
      struct_q <= struct_d;
      fb_q     <= fb_d;
      again_q  <= again_d;
    end
  end

  assign diag_valid    = valid_q;
  assign diag_model    = model_q;
  assign diag_struct   = struct_q;
  assign fallback_used = fb_q;
  assign again_req     = again_q;
endmodule

// File: rtl/diag_arbiter_chk.sv
module diag_arbiter_chk
  import diag_arb_pkg::*;
#(
  parameter int SCORE_W = 12
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         score_valid,
  input logic [N_CLASSES*SCORE_W-1:0] score_bus,
  input logic                         diag_valid,
  input logic [1:0]                   diag_model,
  input logic [1:0]                   diag_struct,
  input logic                         fallback_used,
  input logic                         retrain_req,
  input logic                         again_req
);
  logic [N_CLASSES-1:0] neg;
  for (genvar k = 0; k < N_CLASSES; k++) begin : g_neg
    assign neg[k] = ($signed(score_bus[k*SCORE_W +: SCORE_W]) < 0);
  end

  // R3: a single hit yields a direct, known answer next cycle
  a_r3_unique: assert property (@(posedge clk) disable iff (!rst_n)
    score_valid && $countones(neg) == 1 |=> diag_valid && !fallback_used && !again_req
      && diag_model != CODE_UNKNOWN && diag_struct != CODE_UNKNOWN);

  // R4/R5: a fallback decision always names a structure
  a_r4_fallback_struct: assert property (@(posedge clk) disable iff (!rst_n)
    diag_valid && fallback_used |-> diag_struct != CODE_UNKNOWN && !again_req);

  // R6: a repeat request carries the undiagnosed code
  a_r6_again_code: assert property (@(posedge clk) disable iff (!rst_n)
    again_req |-> diag_valid && diag_model == CODE_UNKNOWN
      && diag_struct == CODE_UNKNOWN && !fallback_used);

  // R7: retrain request is a single-cycle pulse
  a_r7_retrain_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    retrain_req |=> !retrain_req);

  // R10: without a strobe the decision outputs hold
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !score_valid |=> !diag_valid && !again_req && $stable(diag_model)
      && $stable(diag_struct) && $stable(fallback_used));
endmodule

bind diag_arbiter diag_arbiter_chk #(.SCORE_W(SCORE_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .score_valid   (score_valid),
  .score_bus     (score_bus),
  .diag_valid    (diag_valid),
  .diag_model    (diag_model),
  .diag_struct   (diag_struct),
  .fallback_used (fallback_used),
  .retrain_req   (retrain_req),
  .again_req     (again_req)
);

// File: tb/test_diag_arbiter.sv
module test_diag_arbiter;
  localparam int SW  = 12;
  localparam int NC  = 9;
  localparam int LIM = 2;
  localparam int NV  = 13;

  logic            clk, rst_n;
  logic            score_valid;
  logic [NC*SW-1:0] score_bus;
  logic            trap_hit;
  logic [1:0]      trap_struct;
  logic            symptom_pulse;
  logic            diag_valid;
  logic [1:0]      diag_model, diag_struct;
  logic            fallback_used, retrain_req, again_req;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  diag_arbiter #(.SCORE_W(SW), .PERSIST_LIMIT(LIM)) i_diag_arbiter (
    .clk(clk), .rst_n(rst_n), .score_valid(score_valid), .score_bus(score_bus),
    .trap_hit(trap_hit), .trap_struct(trap_struct), .symptom_pulse(symptom_pulse),
    .diag_valid(diag_valid), .diag_model(diag_model), .diag_struct(diag_struct),
    .fallback_used(fallback_used), .retrain_req(retrain_req), .again_req(again_req)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // {hit mask[17:9], trap_hit[8], trap_struct[7:6], model[5:4], struct[3:2], fb[1], again[0]}
  localparam logic [17:0] TBL [0:NV-1] = '{
    {9'b000000001, 1'b0, 2'd0, 2'd0, 2'd0, 1'b0, 1'b0}, // R3 class 0
    {9'b000100000, 1'b0, 2'd0, 2'd1, 2'd2, 1'b0, 1'b0}, // R3 class 5
    {9'b100000000, 1'b0, 2'd0, 2'd2, 2'd2, 1'b0, 1'b0}, // R3 class 8
    {9'b000010000, 1'b0, 2'd0, 2'd1, 2'd1, 1'b0, 1'b0}, // R2 most negative
    {9'b000000000, 1'b1, 2'd1, 2'd3, 2'd1, 1'b1, 1'b0}, // R4
    {9'b000000000, 1'b0, 2'd1, 2'd3, 2'd3, 1'b0, 1'b1}, // R6 no trap
    {9'b000000000, 1'b1, 2'd3, 2'd3, 2'd3, 1'b0, 1'b1}, // R6 unusable trap
    {9'b000010001, 1'b1, 2'd1, 2'd1, 2'd1, 1'b1, 1'b0}, // R5 one in column
    {9'b010000010, 1'b1, 2'd1, 2'd3, 2'd1, 1'b1, 1'b0}, // R5 two in column
    {9'b000001100, 1'b1, 2'd1, 2'd3, 2'd1, 1'b1, 1'b0}, // R5 none in column
    {9'b100000001, 1'b0, 2'd0, 2'd3, 2'd3, 1'b0, 1'b1}, // R6 multi
    {9'b010000000, 1'b1, 2'd0, 2'd2, 2'd1, 1'b0, 1'b0}, // R3 trap ignored
    {9'b111111111, 1'b1, 2'd2, 2'd3, 2'd2, 1'b1, 1'b0}  // R5 all hit
  };

  function automatic logic [NC*SW-1:0] mk_scores(input logic [NC-1:0] mask);
    logic [NC*SW-1:0] v;
    for (int k = 0; k < NC; k++) begin
      if (mask[k])
        v[k*SW +: SW] = (k == 4) ? {1'b1, {(SW-1){1'b0}}} : SW'(-(k + 1));
      else
        v[k*SW +: SW] = (k % 2 == 1) ? '0 : SW'(k * 7 + 3);
    end
    return v;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // drive one cycle starting at a negedge, return at the next negedge
  task automatic step(input bit sv, input logic [NC-1:0] mask, input bit th,
                      input logic [1:0] ts, input bit sym);
    score_valid   = sv;
    score_bus     = mk_scores(mask);
    trap_hit      = th;
    trap_struct   = ts;
    symptom_pulse = sym;
    @(negedge clk);
    score_valid   = 1'b0;
    trap_hit      = 1'b0;
    symptom_pulse = 1'b0;
  endtask

  task automatic chk_dec(input string tag, input logic [1:0] m, input logic [1:0] s,
                         input bit fb, input bit ag);
    chk(diag_valid == 1'b1, {tag, " valid"}, diag_valid, 1);
    chk(diag_model == m, {tag, " model"}, diag_model, m);
    chk(diag_struct == s, {tag, " struct"}, diag_struct, s);
    chk(fallback_used == fb, {tag, " fallback"}, fallback_used, fb);
    chk(again_req == ag, {tag, " again"}, again_req, ag);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    summary();
  end

  initial begin
    rst_n = 1'b0; score_valid = 1'b0; score_bus = '0; trap_hit = 1'b0;
    trap_struct = 2'd0; symptom_pulse = 1'b0;
    repeat (3) @(negedge clk);
    chk(diag_model == 2'd3 && diag_struct == 2'd3, "R1 codes in reset", {diag_model, diag_struct}, 15);
    chk(!diag_valid && !fallback_used && !retrain_req && !again_req, "R1 flags in reset",
        {diag_valid, fallback_used, retrain_req, again_req}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(diag_model == 2'd3 && !diag_valid, "R1 after release", {diag_valid, diag_model}, 3);

    // R8: symptoms with no prior decision
    step(0, '0, 0, 0, 1); step(0, '0, 0, 0, 1);
    chk(!retrain_req, "R8 before any decision", retrain_req, 0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      logic [17:0] e;
      e = TBL[i];
      step(1, e[17:9], e[8], e[7:6], 0);
      chk_dec($sformatf("R2/R3-R6 vector %0d", i), e[5:4], e[3:2], e[1], e[0]);
      @(negedge clk);
      chk(!diag_valid && !again_req && diag_model == e[5:4] && diag_struct == e[3:2]
          && fallback_used == e[1], $sformatf("R10 hold after vector %0d", i),
          {diag_valid, again_req, diag_model, diag_struct}, {2'b00, e[5:2]});
    end

    // R7: unique decision then persistent symptoms
    step(1, 9'b000000001, 0, 0, 0);
    step(0, '0, 0, 0, 1);
    chk(!retrain_req, "R7 first symptom silent", retrain_req, 0);
    step(0, '0, 0, 0, 1);
    chk(retrain_req, "R7 limit reached", retrain_req, 1);
    step(0, '0, 0, 0, 0);
    chk(!retrain_req, "R7 single pulse", retrain_req, 0);
    step(0, '0, 0, 0, 1); step(0, '0, 0, 0, 1);
    chk(!retrain_req, "R7 watch released", retrain_req, 0);

    // R8: after fallback decision
    step(1, 9'b000000000, 1, 2'd2, 0);
    chk(fallback_used, "R8 fallback set up", fallback_used, 1);
    step(0, '0, 0, 0, 1); step(0, '0, 0, 0, 1); step(0, '0, 0, 0, 1);
    chk(!retrain_req, "R8 after fallback", retrain_req, 0);

    // R8: after undiagnosed decision
    step(1, 9'b000000011, 0, 0, 0);
    chk(again_req, "R8 undiagnosed set up", again_req, 1);
    step(0, '0, 0, 0, 1); step(0, '0, 0, 0, 1);
    chk(!retrain_req, "R8 after undiagnosed", retrain_req, 0);

    // R9: new strobe clears count, simultaneous symptom not counted
    step(1, 9'b000000001, 0, 0, 0);
    step(0, '0, 0, 0, 1);
    step(1, 9'b100000000, 0, 0, 1);
    chk_dec("R9 new unique", 2'd2, 2'd2, 0, 0);
    chk(!retrain_req, "R9 no retrain on strobe", retrain_req, 0);
    step(0, '0, 0, 0, 1);
    chk(!retrain_req, "R9 count restarted", retrain_req, 0);
    step(0, '0, 0, 0, 1);
    chk(retrain_req, "R9 limit after restart", retrain_req, 1);

    // R1: mid-run reset
    step(1, 9'b000100000, 0, 0, 0);
    rst_n = 1'b0;
    @(negedge clk);
    chk(diag_model == 2'd3 && diag_struct == 2'd3 && !diag_valid, "R1 mid-run reset",
        {diag_valid, diag_model, diag_struct}, 15);
    rst_n = 1'b1;
    @(negedge clk);
    summary();
  end
endmodule